// File: doc/BRIEF.md
# Serial Register-Access Host

This block is the host side of a four-wire serial link (active-low select, serial clock, host-to-peripheral data, peripheral-to-host data). It reads and writes the 6-bit-addressed registers of an attached peripheral. A user-side request carries a direction flag, a register address, a byte count of 1 to 3 and up to 24 bits of write data. The block sends one frame per request. The frame opens with a command byte and is followed by the data bytes.

Every minimum interval on the wire is built from counters that run on the system clock. This covers select setup and hold, clock high and low widths, the gaps between bytes and the long pause before read data. Each interval is a parameter in nanoseconds. It is converted to clock cycles and rounded up. One register address, the fast-capture register, needs a much shorter pause before its read data than every other register. When a frame ends, a single-cycle done strobe presents the read bytes right-aligned.

Top module: `sreg_host`

## Requirements
- R1: After reset, and at all times while the transfer is idle, `csN` is 1, `sclk` is 1, `busy` is 0 and `done` is 0. `sclk` is never low while `csN` is high.
- R2: Each frame begins with a command byte. Bit 7 of that byte is 1 for a write and 0 for a read. Bit 6 is 0. Bits 5..0 hold the register address. Every byte is sent bit 7 first, and the peripheral samples `mosi` on the falling edge of `sclk`.
- R3: A frame holds exactly 1 + `reqCount` bytes. For a write, the data bytes are the low `reqCount` bytes of `reqWdata`, sent most significant byte first.
- R4: Every high phase and every low phase of `sclk` lasts at least the half-period time (default 50 ns, 13 cycles). While `csN` is low, `mosi` changes only in the cycle where `sclk` rises or the cycle where `csN` falls.
- R5: `csN` falls at least the select setup time (50 ns) before the first falling edge of `sclk`. It rises no sooner than the select hold time (100 ns, 25 cycles) after the last falling edge.
- R6: In a write frame, the interval from the last rising `sclk` edge of one byte to the first falling edge of the next byte is at least 400 ns (100 cycles).
- R7: In a read frame, the interval from the end of the command byte to the first falling edge of the read data is at least 4 us (1000 cycles). For the fast-capture address `WAVE_ADDR` it is at least 500 ns (125 cycles) and shorter than the normal wait.
- R8: In a read frame, consecutive data bytes are separated by at least 50 ns (13 cycles), measured from the end of one byte to the first falling edge of the next.
- R9: `miso` passes through a two-flop synchronizer and is captured at each falling edge of the read data bytes. `done` is high for exactly one cycle at the end of each frame. In that cycle `rdData` holds the read bytes right-aligned with the first byte most significant. For a write frame `rdData` is 0.
- R10: A request is accepted only when `busy` is 0 and `reqCount` is non-zero. `busy` is 1 from the cycle after acceptance until the end of the frame. Requests made while `busy` is 1, and requests with `reqCount` of 0, produce no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 6 | Register address |
| reqCount | input | 2 | Number of data bytes, 1 to 3 |
| reqWdata | input | 24 | Write data, right-aligned |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| rdData | output | 24 | Read data, right-aligned, valid with done |
| csN | output | 1 | Active-low peripheral select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The bench sends writes of one, two and three bytes, which tell apart byte ordering, byte selection and frame length. It sends reads to ordinary addresses and to the fast-capture address, so the long wait, the short wait and the right-alignment of one-, two- and three-byte results are each exposed. A request raised in the middle of a frame and a request with a count of zero check that neither one starts a frame. A peripheral model measures every interval on the wire in system cycles against the nanosecond minimums. Each completed frame and each done strobe is compared with the scoreboard queue.

// File: rtl/sreg_host_pkg.sv
package sreg_host_pkg;

  // Strobes sent from the sequencer to the shift datapath
  typedef struct packed {
    logic       start;    // accept request, lower select, load command byte
    logic       fall;     // drive sclk low
    logic       capture;  // shift one synchronized miso bit into the read shifter
    logic       rise;     // drive sclk high, advance the transmit shifter
    logic       load;     // load the next data byte into the transmit shifter
    logic [1:0] loadIdx;  // data byte index to load, 0 = first sent
    logic       finish;   // raise select, present read data, pulse done
  } hostStrobe_t;

  // Nanoseconds to system clock cycles, rounded up, never less than one
  function automatic int nsToCycles(input longint clkHz, input longint ns);
    longint c;
    c = (ns * clkHz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/sreg_host_ctrl.sv
module sreg_host_ctrl
  import sreg_host_pkg::*;
#(
  parameter int          FIRST_CYC     = 13,
  parameter int          HALF_CYC      = 13,
  parameter int          HOLD_CYC      = 25,
  parameter int          WR_GAP_CYC    = 100,
  parameter int          RD_GAP_CYC    = 13,
  parameter int          RD_WAIT_CYC   = 1000,
  parameter int          WAVE_WAIT_CYC = 125,
  parameter logic [5:0]  WAVE_ADDR     = 6'h09,
  parameter int          CNT_W         = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [5:0]  reqAddr,
  input  logic [1:0]  reqCount,
  output logic        busy,
  output hostStrobe_t stb
);

  localparam logic [CNT_W-1:0] L_FIRST = CNT_W'(FIRST_CYC - 1);
  localparam logic [CNT_W-1:0] L_HALF  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] L_WGAP  = CNT_W'(WR_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] L_RGAP  = CNT_W'(RD_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] L_RWAIT = CNT_W'(RD_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] L_WAVE  = CNT_W'(WAVE_WAIT_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_HIGH, S_LOW, S_GAP, S_HOLD} hostState_t;

  hostState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gapLen;
  logic [2:0]       bitIdx;
  logic [1:0]       byteIdx;   // 0 = command byte, k = data byte k
  logic [1:0]       lastIdx;
  logic             isWr;
  logic             isWave;
  logic             accept;
  logic             phaseEnd;

  assign accept   = (state == S_IDLE) && reqValid && (reqCount != 2'd0);
  assign phaseEnd = (cnt == '0);
  assign busy     = (state != S_IDLE);

  // Wait after a byte, chosen by direction and position in the frame
  always_comb begin
    if (isWr)                 gapLen = L_WGAP;
    else if (byteIdx == 2'd0) gapLen = isWave ? L_WAVE : L_RWAIT;
    else                      gapLen = L_RGAP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
      isWr    <= 1'b0;
      isWave  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_HIGH;
          cnt     <= L_FIRST;
          bitIdx  <= '0;
          byteIdx <= '0;
          lastIdx <= reqCount;
          isWr    <= reqWrite;
          isWave  <= (reqAddr == WAVE_ADDR);
        end
        S_HIGH: if (phaseEnd) begin
          state <= S_LOW;
          cnt   <= L_HALF;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (phaseEnd) begin
          if (bitIdx == 3'd7) begin
            bitIdx <= '0;
            if (byteIdx == lastIdx) begin
              state <= S_HOLD;
              cnt   <= L_HOLD;
            end else begin
              state   <= S_GAP;
              cnt     <= gapLen;
              byteIdx <= byteIdx + 2'd1;
            end
          end else begin
            bitIdx <= bitIdx + 3'd1;
            state  <= S_HIGH;
            cnt    <= L_HALF;
          end
        end else cnt <= cnt - 1'b1;
        S_GAP: if (phaseEnd) begin
          state <= S_HIGH;
          cnt   <= L_HALF;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (phaseEnd) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.start   = accept;
    stb.fall    = (state == S_HIGH) && phaseEnd;
    stb.capture = stb.fall && !isWr && (byteIdx != 2'd0);
    stb.rise    = (state == S_LOW) && phaseEnd;
    stb.load    = stb.rise && (bitIdx == 3'd7) && (byteIdx != lastIdx);
    stb.loadIdx = byteIdx;
    stb.finish  = (state == S_HOLD) && phaseEnd;
  end

  // R10: a zero-count request leaves the block idle
  a_r10_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqCount == 2'd0) |=> !busy);

  // R10: a frame in progress is not cut short by a new request
  a_r10_busy_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && !stb.finish) |=> busy);

endmodule

// File: rtl/sreg_host_dp.sv
module sreg_host_dp
  import sreg_host_pkg::*;
#(
  parameter int HALF_CYC = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  hostStrobe_t stb,
  input  logic        reqWrite,
  input  logic [5:0]  reqAddr,
  input  logic [1:0]  reqCount,
  input  logic [23:0] reqWdata,
  input  logic        miso,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  output logic        done,
  output logic [23:0] rdData
);

  logic [7:0]  txSh;
  logic [23:0] wrLatch;
  logic [23:0] rxSh;
  logic [1:0]  cntLatch;
  logic [1:0]  misoSync;
  logic [1:0]  selIdx;
  logic [7:0]  nextByte;

  assign mosi = txSh[7];

  // Data byte k of n is byte (n-1-k) of the right-aligned write word
  always_comb begin
    selIdx = cntLatch - 2'd1 - stb.loadIdx;
    case (selIdx)
      2'd0:    nextByte = wrLatch[7:0];
      2'd1:    nextByte = wrLatch[15:8];
      default: nextByte = wrLatch[23:16];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN      <= 1'b1;
      sclk     <= 1'b1;
      txSh     <= '0;
      wrLatch  <= '0;
      rxSh     <= '0;
      cntLatch <= '0;
      misoSync <= '0;
      done     <= 1'b0;
      rdData   <= '0;
    end else begin
      misoSync <= {misoSync[0], miso};
      done     <= stb.finish;
      if (stb.start) begin
        csN      <= 1'b0;
        txSh     <= {reqWrite, 1'b0, reqAddr};
        wrLatch  <= reqWrite ? reqWdata : '0;
        cntLatch <= reqCount;
        rxSh     <= '0;
      end
      if (stb.fall)    sclk <= 1'b0;
      if (stb.rise)    sclk <= 1'b1;
      if (stb.capture) rxSh <= {rxSh[22:0], misoSync[1]};
      if (stb.load)      txSh <= nextByte;
      else if (stb.rise) txSh <= {txSh[6:0], 1'b0};
      if (stb.finish) begin
        csN    <= 1'b1;
        rdData <= rxSh;
      end
    end
  end

  // Cycles since the last sclk transition, saturating
  logic [15:0] lvlRun;
  always_ff @(posedge clk) begin
    if (!rstN)                   lvlRun <= '0;
    else if (stb.fall || stb.rise) lvlRun <= '0;
    else if (lvlRun != 16'hFFFF) lvlRun <= lvlRun + 16'd1;
  end

  // R1: clock idles high whenever the select is released
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  // R4: each sclk level is held for at least the half period
  a_r4_half_min: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fall || stb.rise) |-> (32'(lvlRun) + 1 >= HALF_CYC));

  // R5: the clock is still high in the cycle after the select falls
  a_r5_cs_lead: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> sclk);

  // R9: done lasts exactly one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/sreg_host.sv
module sreg_host
  import sreg_host_pkg::*;
#(
  parameter int         CLK_HZ          = 250_000_000,
  parameter int         T_CS_SETUP_NS   = 50,
  parameter int         T_HALF_NS       = 50,
  parameter int         T_CS_HOLD_NS    = 100,
  parameter int         T_WR_BYTE_NS    = 50,
  parameter int         T_WR_END_NS     = 400,
  parameter int         T_RD_BYTE_NS    = 50,
  parameter int         T_RD_WAIT_NS    = 4000,
  parameter int         T_WAVE_WAIT_NS  = 500,
  parameter logic [5:0] WAVE_ADDR       = 6'h09
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [5:0]  reqAddr,
  input  logic [1:0]  reqCount,
  input  logic [23:0] reqWdata,
  output logic        busy,
  output logic        done,
  output logic [23:0] rdData,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);

  localparam int SETUP_CYC     = nsToCycles(CLK_HZ, T_CS_SETUP_NS);
  localparam int HALF_CYC      = nsToCycles(CLK_HZ, T_HALF_NS);
  localparam int FIRST_CYC     = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int HOLD_CYC      = nsToCycles(CLK_HZ, T_CS_HOLD_NS);
  localparam int WB_CYC        = nsToCycles(CLK_HZ, T_WR_BYTE_NS);
  localparam int WE_CYC        = nsToCycles(CLK_HZ, T_WR_END_NS);
  localparam int WR_GAP_CYC    = (WB_CYC > WE_CYC) ? WB_CYC : WE_CYC;
  localparam int RD_GAP_CYC    = nsToCycles(CLK_HZ, T_RD_BYTE_NS);
  localparam int RD_WAIT_CYC   = nsToCycles(CLK_HZ, T_RD_WAIT_NS);
  localparam int WAVE_WAIT_CYC = nsToCycles(CLK_HZ, T_WAVE_WAIT_NS);
  localparam int CNT_W = $clog2(FIRST_CYC + HALF_CYC + HOLD_CYC + WR_GAP_CYC
                                + RD_GAP_CYC + RD_WAIT_CYC + WAVE_WAIT_CYC + 1);

  hostStrobe_t stb;

  sreg_host_ctrl #(
    .FIRST_CYC    (FIRST_CYC),
    .HALF_CYC     (HALF_CYC),
    .HOLD_CYC     (HOLD_CYC),
    .WR_GAP_CYC   (WR_GAP_CYC),
    .RD_GAP_CYC   (RD_GAP_CYC),
    .RD_WAIT_CYC  (RD_WAIT_CYC),
    .WAVE_WAIT_CYC(WAVE_WAIT_CYC),
    .WAVE_ADDR    (WAVE_ADDR),
    .CNT_W        (CNT_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqCount(reqCount),
    .busy    (busy),
    .stb     (stb)
  );

  sreg_host_dp #(
    .HALF_CYC(HALF_CYC)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqCount(reqCount),
    .reqWdata(reqWdata),
    .miso    (miso),
    .csN     (csN),
    .sclk    (sclk),
    .mosi    (mosi),
    .done    (done),
    .rdData  (rdData)
  );

endmodule

// File: tb/test_sreg_host.sv
`timescale 1ns/1ps
module test_sreg_host;

  // Expected cycle minimums at 250 MHz (250 cycles per microsecond), rounded up
  function automatic int ceilCyc(input int ns);
    return (ns * 250 + 999) / 1000;
  endfunction
  localparam int B_HALF  = ceilCyc(50);
  localparam int B_SETUP = ceilCyc(50);
  localparam int B_HOLD  = ceilCyc(100);
  localparam int B_WGAP  = ceilCyc(400);
  localparam int B_RGAP  = ceilCyc(50);
  localparam int B_RWAIT = ceilCyc(4000);
  localparam int B_WAVE  = ceilCyc(500);
  localparam logic [5:0] WAVE = 6'h09;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [5:0]  reqAddr = '0;
  logic [1:0]  reqCount = '0;
  logic [23:0] reqWdata = '0;
  logic        busy, done, csN, sclk, mosi;
  logic        miso = 1'b1;
  logic [23:0] rdData;

  always #2 clk = ~clk;

  sreg_host #(.WAVE_ADDR(WAVE)) i_sreg_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqCount(reqCount), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rdData(rdData),
    .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  typedef struct {
    logic [7:0]  cmd;
    int          n;
    logic [23:0] wdata;
    logic [23:0] rd;
  } exp_t;

  exp_t frameQ[$];
  exp_t doneQ[$];
  int nChecks = 0;
  int nErr = 0;
  int frames = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Peripheral register contents served on reads
  function automatic logic [23:0] pat(input logic [5:0] a);
    return {2'b10, a, ~{2'b01, a}, 8'h5A ^ {a, 2'b11}};
  endfunction

  function automatic logic [23:0] lowBytes(input logic [23:0] d, input int n);
    return d & ((24'h1 << (8 * n)) - 24'h1);
  endfunction

  // Driver: push the expected frame and result, then pulse the request
  task automatic issue(input logic w, input logic [5:0] a, input logic [1:0] n,
                       input logic [23:0] d);
    exp_t e;
    e.cmd   = {w, 1'b0, a};
    e.n     = int'(n);
    e.wdata = lowBytes(d, int'(n));
    e.rd    = w ? 24'h0 : (pat(a) >> (8 * (3 - int'(n))));
    frameQ.push_back(e);
    doneQ.push_back(e);
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqCount = n; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    repeat (5) @(negedge clk);
  endtask

  // Monitor and peripheral model, sampling away from the active edge
  int cyc = 0;
  int tCs = 0, tChg = 0, tLastFall = 0, tByteEnd = 0, bitCnt = 0;
  logic [7:0]  curByte = '0, cmdSeen = '0;
  logic [23:0] dataSeen = '0, misoSh = '0;
  logic prevCs = 1'b1, prevSclk = 1'b1, prevMosi = 1'b0, prevDone = 1'b0;

  always @(negedge clk) begin
    exp_t e;
    int need;
    cyc++;
    if (rstN) begin
      if (csN) check(sclk == 1'b1, "R1 sclk high while idle", sclk, 1);
      if (prevCs && !csN) begin
        tCs = cyc; bitCnt = 0; dataSeen = '0;
      end
      if (!csN && !prevCs && (mosi != prevMosi))
        check(!prevSclk && sclk, "R4 mosi changes only at rising sclk", mosi, prevMosi);
      if (!csN && prevSclk && !sclk) begin
        check(cyc - tChg >= B_HALF, "R4 sclk high width", cyc - tChg, B_HALF);
        if (bitCnt == 0)
          check(cyc - tCs >= B_SETUP, "R5 select setup", cyc - tCs, B_SETUP);
        else if (bitCnt % 8 == 0) begin
          if (cmdSeen[7])
            check(cyc - tByteEnd >= B_WGAP, "R6 write byte gap", cyc - tByteEnd, B_WGAP);
          else if (bitCnt == 8 && cmdSeen[5:0] == WAVE) begin
            check(cyc - tByteEnd >= B_WAVE, "R7 fast-capture wait min", cyc - tByteEnd, B_WAVE);
            check(cyc - tByteEnd < B_RWAIT, "R7 fast-capture wait shorter", cyc - tByteEnd, B_RWAIT);
          end else if (bitCnt == 8)
            check(cyc - tByteEnd >= B_RWAIT, "R7 read wait", cyc - tByteEnd, B_RWAIT);
          else
            check(cyc - tByteEnd >= B_RGAP, "R8 read byte gap", cyc - tByteEnd, B_RGAP);
        end
        curByte = {curByte[6:0], mosi};
        bitCnt++;
        if (bitCnt == 8) cmdSeen = curByte;
        else if (bitCnt % 8 == 0) dataSeen = {dataSeen[15:0], curByte};
        tChg = cyc; tLastFall = cyc;
      end
      if (!csN && !prevSclk && sclk) begin
        check(cyc - tChg >= B_HALF, "R4 sclk low width", cyc - tChg, B_HALF);
        tChg = cyc;
        if (bitCnt % 8 == 0) tByteEnd = cyc;
        if (bitCnt >= 8 && !cmdSeen[7]) begin
          if (bitCnt == 8) misoSh = pat(cmdSeen[5:0]);
          miso = misoSh[23];
          misoSh = {misoSh[22:0], 1'b1};
        end
      end
      if (!prevCs && csN) begin
        check(cyc - tLastFall >= B_HOLD, "R5 select hold", cyc - tLastFall, B_HOLD);
        frames++;
        miso = 1'b1;
        if (frameQ.size() == 0) check(1'b0, "R10 unexpected frame", cmdSeen, 0);
        else begin
          e = frameQ.pop_front();
          check(cmdSeen == e.cmd, "R2 command byte", cmdSeen, e.cmd);
          check(bitCnt == 8 * (e.n + 1), "R3 frame length", bitCnt, 8 * (e.n + 1));
          if (e.cmd[7]) check(dataSeen == e.wdata, "R3 write bytes", dataSeen, e.wdata);
        end
      end
      if (done) begin
        check(!prevDone, "R9 done single cycle", prevDone, 0);
        if (doneQ.size() == 0) check(1'b0, "R10 unexpected done", 1, 0);
        else begin
          e = doneQ.pop_front();
          check(rdData == e.rd, "R9 read data", rdData, e.rd);
        end
      end
    end
    prevCs = csN; prevSclk = sclk; prevMosi = mosi; prevDone = done;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=%0d expected=0", frameQ.size());
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(csN == 1'b1, "R1 reset csN", csN, 1);
    check(sclk == 1'b1, "R1 reset sclk", sclk, 1);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    issue(1'b1, 6'h12, 2'd1, 24'hFFFFA5); waitIdle();
    issue(1'b1, 6'h2C, 2'd3, 24'h123456); waitIdle();
    issue(1'b1, 6'h3F, 2'd2, 24'h77BEEF); waitIdle();
    issue(1'b0, 6'h05, 2'd1, 24'h0);      waitIdle();
    issue(1'b0, 6'h21, 2'd3, 24'h0);      waitIdle();
    issue(1'b0, WAVE,  2'd2, 24'h0);      waitIdle();
    issue(1'b0, WAVE,  2'd3, 24'h0);      waitIdle();

    // R10: a request raised during a frame is dropped
    issue(1'b0, 6'h07, 2'd2, 24'h0);
    repeat (20) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 6'h3E; reqCount = 2'd3; reqWdata = 24'hABCDEF;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();

    // R10: a zero-count request is dropped
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 6'h11; reqCount = 2'd0;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b0, "R10 zero count not accepted", busy, 0);
    repeat (40) @(negedge clk);
    check(csN == 1'b1, "R10 zero count no frame", csN, 1);

    check(frames == 8, "R10 frame total", frames, 8);
    check(frameQ.size() == 0, "R3 all frames seen", frameQ.size(), 0);
    check(doneQ.size() == 0, "R9 all done strobes seen", doneQ.size(), 0);
    summary();
    $finish;
  end

endmodule